// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block records the moment at which an external event happens, measured against a free-running 16-bit counter that lives elsewhere in the timer. Two digital event sources are offered: a device input pin and the digital output of an analog comparator. A control input picks one of them. The chosen signal is synchronized and can optionally be passed through a noise filter. An edge detector then looks for either rising or falling transitions. When a qualifying transition is seen, the counter value is stored in a 16-bit capture register and a capture flag is raised. That flag drives an interrupt request when interrupts are enabled.

Software reaches the 16-bit capture register over an 8-bit read port. A low-byte read also parks the matching high byte in a temporary latch. A later high-byte read returns that latch, so the two halves always belong to the same capture, even if a new event arrives between the two reads. The flag is cleared by a write strobe or by an interrupt-acknowledge pulse. The block keeps the detector from reporting false events when the source, polarity or filter setting is changed.

Top module: `stamp_capture`

## Requirements
- R1: `src_sel_i` = 0 takes events from `pin_i`, and `src_sel_i` = 1 takes them from `cmp_i`. Activity on the source that is not selected never sets the flag.
- R2: With the filter off, a level change on the selected source that is present at rising edge e0 leaves the flag clear after e1 and sets it at e2. A one-cycle pulse is enough to cause a capture.
- R3: `edge_rise_i` = 1 captures on 0-to-1 transitions and `edge_rise_i` = 0 captures on 1-to-0 transitions. The opposite transition never sets the flag.
- R4: On a capture, the capture register takes the value `count_i` had at the clock edge on which the flag is set. Without a capture, the register holds its value.
- R5: The flag is set on the same clock edge that loads the capture register. It is cleared one edge after `flag_clr_i` or `ack_i` is high. If a capture and a clear fall on the same edge, the capture wins and the flag stays 1.
- R6: `irq_o` is high exactly when the flag is 1 and `irq_en_i` is 1.
- R7: With `filt_en_i` = 1, the filtered level follows the synchronized source only after four equal consecutive samples. This moves the flag-set edge from e2 to e6, and a pulse shorter than four cycles never causes a capture.
- R8: While `rd_lo_i` is high, `rd_data_o` shows capture bits 7:0, and the next clock edge copies capture bits 15:8 into the temporary latch. While only `rd_hi_i` is high, `rd_data_o` shows the temporary latch. `rd_lo_i` has priority over `rd_hi_i`. With neither strobe high, `rd_data_o` is 0.
- R9: A change of `src_sel_i`, `edge_rise_i` or `filt_en_i` blocks any capture in that cycle. It also reloads the synchronizer, the filter and the detector history from the newly selected source, so the change alone never sets the flag.
- R10: After reset, the capture register, the temporary latch and the flag are 0, and `irq_o` and `rd_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 16 | Current value of the free-running timer counter |
| pin_i | input | 1 | Asynchronous external event pin |
| cmp_i | input | 1 | Analog comparator output as a digital level |
| src_sel_i | input | 1 | 0 selects the pin, 1 selects the comparator |
| filt_en_i | input | 1 | Enables the four-sample noise filter |
| edge_rise_i | input | 1 | 1 selects rising edges, 0 selects falling edges |
| irq_en_i | input | 1 | Capture interrupt enable |
| flag_clr_i | input | 1 | Software write-one strobe that clears the flag |
| ack_i | input | 1 | Interrupt acknowledge pulse that clears the flag |
| rd_lo_i | input | 1 | Low-byte read strobe; latches the high byte |
| rd_hi_i | input | 1 | High-byte read strobe |
| rd_data_o | output | 8 | Read data |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Capture interrupt request |

## Verification
The assertions assume that `count_i` and the control inputs change only between clock edges. Read and clear strobes are treated as single-cycle levels sampled at the edge. Only the event sources are treated as asynchronous. The bench drives every input on the falling clock edge and holds both sources low through reset, so that no capture is provoked by the reset value of the synchronizer. It also holds the control settings steady for several cycles before any timed event, so that the change-suppression window of R9 never overlaps a latency measurement.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int CNT_W    = 16;
  localparam int BUS_W    = 8;
  localparam int SYNC_LEN = 2;
  localparam int FILT_LEN = 4;

  // Qualifying transition between the previous and the current level.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  // True when the lowest n bits of v all carry the same value.
  function automatic logic uniform(input logic [31:0] v, input int n);
    logic ones, zeros;
    ones  = 1'b1;
    zeros = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < n) begin
        ones  = ones & v[i];
        zeros = zeros & ~v[i];
      end
    end
    return ones | zeros;
  endfunction
endpackage

// File: rtl/icu_front.sv
module icu_front
  import icu_pkg::*;
#(
  parameter int SYNC = SYNC_LEN,
  parameter int FLEN = FILT_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic cmp_i,
  input  logic src_sel_i,
  input  logic filt_en_i,
  input  logic reload_i,
  output logic sel_o,
  output logic level_o
);
  logic [SYNC-1:0] sync_q;
  logic            synced;

  assign sel_o  = src_sel_i ? cmp_i : pin_i;
  assign synced = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sync_q <= '0;
    else if (reload_i) sync_q <= {SYNC{sel_o}};
    else               sync_q <= {sync_q[SYNC-2:0], sel_o};
  end

  generate
    if (FLEN > 1) begin : g_filter
      localparam int WL = FLEN - 1;
      logic [WL-1:0] win_q;
      logic          filt_q;
      logic [31:0]   samples;

      assign samples = 32'({win_q, synced});

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          win_q  <= '0;
          filt_q <= 1'b0;
        end else if (reload_i) begin
          win_q  <= {WL{sel_o}};
          filt_q <= sel_o;
        end else begin
          win_q <= {win_q[WL-2:0], synced};
          if (uniform(samples, FLEN)) filt_q <= synced;
        end
      end

      assign level_o = filt_en_i ? filt_q : synced;
    end else begin : g_nofilter
      assign level_o = synced;
    end
  endgenerate
endmodule

// File: rtl/icu_edge.sv
module icu_edge
  import icu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic sel_i,
  input  logic src_sel_i,
  input  logic filt_en_i,
  input  logic edge_rise_i,
  output logic ctrl_chg_o,
  output logic cap_evt_o
);
  logic       prev_q;
  logic [2:0] ctrl_q;
  logic [2:0] ctrl_now;

  assign ctrl_now   = {src_sel_i, filt_en_i, edge_rise_i};
  assign ctrl_chg_o = (ctrl_now != ctrl_q);
  assign cap_evt_o  = edge_hit(level_i, prev_q, edge_rise_i) & ~ctrl_chg_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_now;
      prev_q <= ctrl_chg_o ? sel_i : level_i;
    end
  end
endmodule

// File: rtl/icu_regs.sv
module icu_regs
  import icu_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_evt_i,
  input  logic [CW-1:0] count_i,
  input  logic          flag_clr_i,
  input  logic          ack_i,
  input  logic          rd_lo_i,
  input  logic          rd_hi_i,
  output logic [CW-1:0] cap_o,
  output logic [BW-1:0] temp_o,
  output logic [BW-1:0] rd_data_o,
  output logic          flag_o
);
  localparam int HW = CW - BW;

  logic [CW-1:0] cap_q;
  logic [HW-1:0] temp_q;
  logic          flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      temp_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_evt_i)              cap_q  <= count_i;
      if (rd_lo_i)                temp_q <= cap_q[CW-1:BW];
      if (cap_evt_i)              flag_q <= 1'b1;
      else if (flag_clr_i | ack_i) flag_q <= 1'b0;
    end
  end

  always_comb begin
    if (rd_lo_i)      rd_data_o = cap_q[BW-1:0];
    else if (rd_hi_i) rd_data_o = BW'(temp_q);
    else              rd_data_o = '0;
  end

  assign cap_o  = cap_q;
  assign temp_o = BW'(temp_q);
  assign flag_o = flag_q;
endmodule

// File: rtl/stamp_capture.sv
module stamp_capture
  import icu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pin_i,
  input  logic             cmp_i,
  input  logic             src_sel_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             irq_en_i,
  input  logic             flag_clr_i,
  input  logic             ack_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic             sel_lvl;
  logic             level;
  logic             ctrl_chg;
  logic             cap_evt;
  logic [CNT_W-1:0] cap_q;
  logic [BUS_W-1:0] temp_q;

  icu_front #(.SYNC(SYNC_LEN), .FLEN(FILT_LEN)) u_front (
    .clk, .rst_n, .pin_i, .cmp_i, .src_sel_i, .filt_en_i,
    .reload_i(ctrl_chg), .sel_o(sel_lvl), .level_o(level)
  );

  icu_edge u_edge (
    .clk, .rst_n, .level_i(level), .sel_i(sel_lvl), .src_sel_i,
    .filt_en_i, .edge_rise_i, .ctrl_chg_o(ctrl_chg), .cap_evt_o(cap_evt)
  );

  icu_regs #(.CW(CNT_W), .BW(BUS_W)) u_regs (
    .clk, .rst_n, .cap_evt_i(cap_evt), .count_i, .flag_clr_i, .ack_i,
    .rd_lo_i, .rd_hi_i, .cap_o(cap_q), .temp_o(temp_q),
    .rd_data_o, .flag_o
  );

  assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/icu_checker.sv
module icu_checker
  import icu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_i,
  input logic             irq_en_i,
  input logic             flag_clr_i,
  input logic             ack_i,
  input logic             rd_lo_i,
  input logic             flag_o,
  input logic             irq_o,
  input logic             cap_evt,
  input logic             ctrl_chg,
  input logic [CNT_W-1:0] cap_q,
  input logic [BUS_W-1:0] temp_q
);
  assert_cap_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_q == $past(count_i));

  assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_o);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i || ack_i) && !cap_evt |=> !flag_o);

  assert_irq_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o && irq_en_i |-> irq_o);

  assert_irq_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_o |-> !irq_o);

  assert_temp_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo_i |=> temp_q == $past(cap_q[CNT_W-1:BUS_W]));

  assert_no_cap_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_chg |-> !cap_evt);
endmodule

bind stamp_capture icu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i), .irq_en_i(irq_en_i),
  .flag_clr_i(flag_clr_i), .ack_i(ack_i), .rd_lo_i(rd_lo_i),
  .flag_o(flag_o), .irq_o(irq_o), .cap_evt(cap_evt), .ctrl_chg(ctrl_chg),
  .cap_q(cap_q), .temp_q(temp_q)
);

// File: tb/stamp_capture_bench.sv
module stamp_capture_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] count_i = '0;
  logic        pin_i = 1'b0, cmp_i = 1'b0;
  logic        src_sel_i = 1'b0, filt_en_i = 1'b0, edge_rise_i = 1'b1;
  logic        irq_en_i = 1'b0, flag_clr_i = 1'b0, ack_i = 1'b0;
  logic        rd_lo_i = 1'b0, rd_hi_i = 1'b0;
  logic [7:0]  rd_data_o;
  logic        flag_o, irq_o;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stamp_capture u_stamp_capture (
    .clk, .rst_n, .count_i, .pin_i, .cmp_i, .src_sel_i, .filt_en_i,
    .edge_rise_i, .irq_en_i, .flag_clr_i, .ack_i, .rd_lo_i, .rd_hi_i,
    .rd_data_o, .flag_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_lo(input string req, input logic [7:0] exp);
    rd_lo_i = 1'b1;
    #1 check(req, rd_data_o, exp);
    step(1);
    rd_lo_i = 1'b0;
  endtask

  task automatic read_hi(input string req, input logic [7:0] exp);
    rd_hi_i = 1'b1;
    #1 check(req, rd_data_o, exp);
    step(1);
    rd_hi_i = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 flag after reset", flag_o, 0);
    check("R10 irq after reset", irq_o, 0);
    check("R10 idle read data", rd_data_o, 0);
    read_lo("R10 capture low after reset", 8'h00);
    read_hi("R10 latch after reset", 8'h00);
  endtask

  task automatic t_rise_basic();
    count_i = 16'h1234;
    pin_i = 1'b1;
    step(2);
    check("R2 flag still clear after e1", flag_o, 0);
    step(1);
    check("R2 flag set at e2", flag_o, 1);
    read_lo("R4 captured low byte", 8'h34);
    clear_flag();
    check("R5 flag cleared by write", flag_o, 0);
    pin_i = 1'b0;
    step(5);
    check("R3 falling edge ignored in rising mode", flag_o, 0);
  endtask

  task automatic t_fall();
    edge_rise_i = 1'b0;
    step(4);
    count_i = 16'h5678;
    pin_i = 1'b1;
    step(5);
    check("R3 rising edge ignored in falling mode", flag_o, 0);
    pin_i = 1'b0;
    step(3);
    check("R3 falling edge captured", flag_o, 1);
    read_lo("R8 low byte of falling capture", 8'h78);
    read_hi("R8 high byte from latch", 8'h56);
    clear_flag();
  endtask

  task automatic t_source();
    edge_rise_i = 1'b1;
    src_sel_i   = 1'b1;
    step(4);
    clear_flag();
    pin_i = 1'b1;
    step(5);
    check("R1 unselected pin ignored", flag_o, 0);
    count_i = 16'h2468;
    cmp_i = 1'b1;
    step(3);
    check("R1 comparator edge captured", flag_o, 1);
    read_lo("R1 comparator capture value", 8'h68);
    clear_flag();
  endtask

  task automatic t_switch();
    cmp_i = 1'b0;
    step(5);
    check("R3 comparator fall ignored", flag_o, 0);
    src_sel_i = 1'b0;
    step(6);
    check("R9 source switch onto high pin", flag_o, 0);
    filt_en_i = 1'b1;
    step(8);
    check("R9 filter enable change", flag_o, 0);
    filt_en_i = 1'b0;
    pin_i = 1'b0;
    step(6);
    clear_flag();
  endtask

  task automatic t_filter();
    filt_en_i = 1'b1;
    step(8);
    clear_flag();
    count_i = 16'h9ABC;
    pin_i = 1'b1;
    step(3);
    pin_i = 1'b0;
    step(10);
    check("R7 three-cycle pulse rejected", flag_o, 0);
    pin_i = 1'b1;
    step(6);
    check("R7 flag clear after e5", flag_o, 0);
    step(1);
    check("R7 flag set at e6", flag_o, 1);
    read_lo("R7 filtered capture value", 8'hBC);
    pin_i = 1'b0;
    step(8);
    filt_en_i = 1'b0;
    step(4);
    clear_flag();
  endtask

  task automatic t_flag_irq();
    irq_en_i = 1'b1;
    count_i = 16'h0F0F;
    pin_i = 1'b1;
    step(1);
    pin_i = 1'b0;
    step(2);
    check("R2 one-cycle pulse captured", flag_o, 1);
    check("R6 irq with enable", irq_o, 1);
    irq_en_i = 1'b0;
    #1 check("R6 irq masked", irq_o, 0);
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
    check("R5 flag cleared by acknowledge", flag_o, 0);
    count_i = 16'hA1B2;
    pin_i = 1'b1;
    step(2);
    flag_clr_i = 1'b1;
    step(1);
    flag_clr_i = 1'b0;
    check("R5 capture wins over clear", flag_o, 1);
  endtask

  task automatic t_coherent();
    read_lo("R8 low byte first capture", 8'hB2);
    clear_flag();
    pin_i = 1'b0;
    step(4);
    count_i = 16'hC3D4;
    pin_i = 1'b1;
    step(3);
    check("R4 second capture flag", flag_o, 1);
    read_hi("R8 latch keeps older high byte", 8'hA1);
    read_lo("R8 low byte second capture", 8'hD4);
    rd_lo_i = 1'b1;
    rd_hi_i = 1'b1;
    #1 check("R8 low strobe has priority", rd_data_o, 8'hD4);
    step(1);
    rd_lo_i = 1'b0;
    #1 check("R8 high byte second capture", rd_data_o, 8'hC3);
    step(1);
    rd_hi_i = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_rise_basic();
    t_fall();
    t_source();
    t_switch();
    t_filter();
    t_flag_irq();
    t_coherent();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule